// File: doc/BRIEF.md
# Serial Register Access Port

This block is the host-facing serial slave of a sampling converter. It lets a host reach the converter's on-chip registers one 16-bit frame at a time. The host lowers an active-low frame strobe, toggles a serial clock and moves data in both directions at once. Incoming bits form a write word: a 2-bit target address followed by a 14-bit payload. At the same time the block shifts out a 16-bit read word. The read word comes from whichever source is chosen by a read-selector field held in the control register.

The block stores the control word, the test word and a bank of ten calibration words. The conversion result and the status word come in as inputs. The control word goes out to the converter core. A host that never writes (serial input tied low) sees a read-only device that returns conversion results.

A small frame state machine sequences every transfer. Its states are ST_IDLE, ST_SHIFT, ST_COMMIT and ST_HOLD:
- ST_IDLE to ST_SHIFT when the strobe goes low; the read word is loaded at this point.
- ST_SHIFT to ST_COMMIT on the 16th rising serial clock edge.
- ST_COMMIT to ST_HOLD after one cycle; this is the only cycle in which registers are updated.
- From any state to ST_IDLE whenever the strobe is high.

Top module: `serial_reg_port`

## Requirements
- R1: A frame carries 16 bits, most significant bit first, each sampled on a rising edge of `sclk` while `frame_n` is low. Bits 15:14 of the frame are the write address and bits 13:0 are the payload.
- R2: Registers change only after the 16th rising edge of a frame. A frame whose strobe rises earlier changes nothing, and bits that arrive after the 16th are ignored.
- R3: Write address 00 discards the payload. Address 01 writes the test word, 10 writes the selected calibration word and 11 writes the control word; the control word is visible on `ctrl_o`.
- R4: The read source is control bits 7:6. Value 00 reads the conversion result, 01 the test word, 10 the selected calibration word and 11 `status_in`. Test and calibration words read back as two zero bits followed by the 14-bit value.
- R5: The read selection resets to 00 and stays in force for every later frame until a control write changes it. A new selection applies from the next frame onward.
- R6: A conversion-result read returns four zero bits followed by the 12-bit `result_in`, captured when the frame starts.
- R7: `sdo` presents the read word most significant bit first. The first bit is valid once the frame has started, and the output advances on each falling edge of `sclk`.
- R8: The calibration bank holds ten words: index 0 is gain, index 1 is offset, and indices 2 to 9 are the DAC words. Control bits 1:0 choose the subset that is stepped through: 00 covers all ten in index order, 01 covers gain then offset, 10 covers offset only and 11 covers gain only.
- R9: The calibration pointer sits on the first word of the subset after reset and after every control write. It advances by one after each completed frame that writes address 10 or reads with selection 10, and it wraps from the last word of the subset to the first.
- R10: After reset `ctrl_o` is zero. Frames sent with `sdi` held low leave all stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the serial lines are sampled with it |
| rst_n | input | 1 | Active-low reset |
| sclk | input | 1 | Serial clock from the host |
| frame_n | input | 1 | Active-low frame strobe; high returns the block to idle |
| sdi | input | 1 | Serial write data |
| sdo | output | 1 | Serial read data |
| result_in | input | 12 | Latest conversion result |
| status_in | input | 16 | Status word from the converter core |
| ctrl_o | output | 14 | Stored control word |

## Verification
The hardest state to reach from the ports is the calibration pointer sitting at a chosen word of a chosen subset. The pointer is hidden and is moved both by writes and by reads. The stimulus first loads all ten words through successive address-10 frames with selection 10. This fills the bank in pointer order and proves the wrap. The bench then re-programs the subset field and reads the same words back frame by frame, so the pointer's position is made visible through `sdo`. Aborted and over-long frames are driven around control writes, so that only `ctrl_o` and later reads can show whether a commit took place.

// File: rtl/srf_pkg.sv
package srf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_COMMIT,
        ST_HOLD
    } srf_state_e;

    localparam logic [1:0] ADR_NONE = 2'b00;
    localparam logic [1:0] ADR_TEST = 2'b01;
    localparam logic [1:0] ADR_CAL  = 2'b10;
    localparam logic [1:0] ADR_CTRL = 2'b11;

    localparam logic [1:0] RD_RESULT = 2'b00;
    localparam logic [1:0] RD_TEST   = 2'b01;
    localparam logic [1:0] RD_CAL    = 2'b10;
    localparam logic [1:0] RD_STATUS = 2'b11;
endpackage

// File: rtl/srf_frame_fsm.sv
module srf_frame_fsm
    import srf_pkg::*;
#(
    parameter int FRAME_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_q,
    input  logic       sclk_rise,
    output srf_state_e state_o,
    output logic       load_o,
    output logic       shift_en_o,
    output logic       commit_o
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    srf_state_e state_q, state_d;
    logic [CNT_W-1:0] bit_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (state_q == ST_IDLE) begin
            bit_cnt <= '0;
        end else if (state_q == ST_SHIFT && sclk_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        if (frame_q) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_SHIFT;
                ST_SHIFT:  if (sclk_rise && bit_cnt == LAST_BIT) state_d = ST_COMMIT;
                ST_COMMIT: state_d = ST_HOLD;
                ST_HOLD:   state_d = ST_HOLD;
            endcase
        end
    end

    always_comb begin
        load_o     = (state_q == ST_IDLE) && !frame_q;
        shift_en_o = (state_q == ST_SHIFT);
        commit_o   = (state_q == ST_COMMIT);
    end

    assign state_o = state_q;
endmodule

// File: rtl/srf_cal_bank.sv
module srf_cal_bank #(
    parameter int DATA_W = 14,
    parameter int DAC_N  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        subset,
    input  logic              ptr_rst,
    input  logic              step,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [3:0]        ptr_o
);
    localparam int CAL_N = DAC_N + 2;
    localparam int PTR_W = $clog2(CAL_N);
    localparam logic [PTR_W-1:0] IDX_GAIN = PTR_W'(0);
    localparam logic [PTR_W-1:0] IDX_OFFS = PTR_W'(1);
    localparam logic [PTR_W-1:0] IDX_LAST = PTR_W'(CAL_N - 1);

    logic [DATA_W-1:0] cal_q [CAL_N];
    logic [PTR_W-1:0]  ptr, first_idx, last_idx;

    always_comb begin
        unique case (subset)
            2'b00: begin first_idx = IDX_GAIN; last_idx = IDX_LAST; end
            2'b01: begin first_idx = IDX_GAIN; last_idx = IDX_OFFS; end
            2'b10: begin first_idx = IDX_OFFS; last_idx = IDX_OFFS; end
            2'b11: begin first_idx = IDX_GAIN; last_idx = IDX_GAIN; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= IDX_GAIN;
        end else if (ptr_rst) begin
            ptr <= first_idx;
        end else if (step) begin
            ptr <= (ptr == last_idx) ? first_idx : ptr + 1'b1;
        end
    end

    for (genvar g = 0; g < CAL_N; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cal_q[g] <= '0;
            end else if (wr_en && ptr == PTR_W'(g)) begin
                cal_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = cal_q[ptr];
    assign ptr_o   = 4'(ptr);
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
    import srf_pkg::*;
#(
    parameter int FRAME_W    = 16,
    parameter int ADDR_W     = 2,
    parameter int RES_W      = 12,
    parameter int DAC_N      = 8,
    parameter int RDSEL_LSB  = 6,
    parameter int CALSEL_LSB = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sclk,
    input  logic                        frame_n,
    input  logic                        sdi,
    output logic                        sdo,
    input  logic [RES_W-1:0]            result_in,
    input  logic [FRAME_W-1:0]          status_in,
    output logic [FRAME_W-ADDR_W-1:0]   ctrl_o
);
    localparam int DATA_W = FRAME_W - ADDR_W;

    srf_state_e        state;
    logic              sclk_q, frame_q;
    logic              sclk_rise, sclk_fall;
    logic              load, shift_en, commit;
    logic [FRAME_W-1:0] in_sr, out_sr, rd_word;
    logic [DATA_W-1:0] ctrl_q, test_q, cal_rd, wr_data;
    logic [ADDR_W-1:0] wr_addr;
    logic [1:0]        rdsel, cal_subset;
    logic              ctrl_wr, test_wr, cal_wr, cal_step;
    logic [3:0]        cal_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            frame_q <= 1'b1;
        end else begin
            sclk_q  <= sclk;
            frame_q <= frame_n;
        end
    end

    assign sclk_rise = sclk & ~sclk_q;
    assign sclk_fall = ~sclk & sclk_q;

    srf_frame_fsm #(.FRAME_W(FRAME_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_q    (frame_q),
        .sclk_rise  (sclk_rise),
        .state_o    (state),
        .load_o     (load),
        .shift_en_o (shift_en),
        .commit_o   (commit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_sr  <= '0;
            out_sr <= '0;
        end else begin
            if (shift_en && sclk_rise) in_sr <= {in_sr[FRAME_W-2:0], sdi};
            if (load) begin
                out_sr <= rd_word;
            end else if (shift_en && sclk_fall) begin
                out_sr <= {out_sr[FRAME_W-2:0], 1'b0};
            end
        end
    end

    assign wr_addr = in_sr[FRAME_W-1 -: ADDR_W];
    assign wr_data = in_sr[DATA_W-1:0];
    assign ctrl_wr = commit && (wr_addr == ADR_CTRL);
    assign test_wr = commit && (wr_addr == ADR_TEST);
    assign cal_wr  = commit && (wr_addr == ADR_CAL);
    assign rdsel   = ctrl_q[RDSEL_LSB +: 2];
    assign cal_step = commit && ((wr_addr == ADR_CAL) || (rdsel == RD_CAL));
    assign cal_subset = ctrl_wr ? wr_data[CALSEL_LSB +: 2] : ctrl_q[CALSEL_LSB +: 2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            test_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= wr_data;
            if (test_wr) test_q <= wr_data;
        end
    end

    srf_cal_bank #(.DATA_W(DATA_W), .DAC_N(DAC_N)) u_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .subset  (cal_subset),
        .ptr_rst (ctrl_wr),
        .step    (cal_step),
        .wr_en   (cal_wr),
        .wr_data (wr_data),
        .rd_data (cal_rd),
        .ptr_o   (cal_ptr)
    );

    always_comb begin
        unique case (rdsel)
            RD_RESULT: rd_word = {{(FRAME_W-RES_W){1'b0}}, result_in};
            RD_TEST:   rd_word = {{ADDR_W{1'b0}}, test_q};
            RD_CAL:    rd_word = {{ADDR_W{1'b0}}, cal_rd};
            RD_STATUS: rd_word = status_in;
        endcase
    end

    assign sdo    = out_sr[FRAME_W-1];
    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/srf_checker.sv
module srf_checker
    import srf_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int DATA_W  = 14,
    parameter int RES_W   = 12,
    parameter int CAL_N   = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_q,
    input srf_state_e         state,
    input logic               load,
    input logic               commit,
    input logic [1:0]         wr_addr,
    input logic [1:0]         rdsel,
    input logic [FRAME_W-1:0] out_sr,
    input logic [DATA_W-1:0]  ctrl_o,
    input logic [DATA_W-1:0]  test_q,
    input logic [3:0]         cal_ptr
);
    // R2
    ctrl_needs_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o != $past(ctrl_o)) |-> $past(commit));

    // R2
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R2
    strobe_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_q |=> (state == ST_IDLE));

    // R3
    null_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && wr_addr == ADR_NONE) |=> ($stable(test_q) && $stable(ctrl_o)));

    // R6
    result_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && rdsel == RD_RESULT) |=> (out_sr[FRAME_W-1:RES_W] == '0));

    // R9
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cal_ptr) < CAL_N);
endmodule

bind serial_reg_port srf_checker #(
    .FRAME_W (FRAME_W),
    .DATA_W  (DATA_W),
    .RES_W   (RES_W),
    .CAL_N   (DAC_N + 2)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_q (frame_q),
    .state   (state),
    .load    (load),
    .commit  (commit),
    .wr_addr (wr_addr),
    .rdsel   (rdsel),
    .out_sr  (out_sr),
    .ctrl_o  (ctrl_o),
    .test_q  (test_q),
    .cal_ptr (cal_ptr)
);

// File: tb/sim_serial_reg_port.sv
module sim_serial_reg_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        frame_n = 1'b1;
    logic        sdi = 1'b0;
    logic        sdo;
    logic [11:0] result_in = 12'hABC;
    logic [15:0] status_in = 16'h0000;
    logic [13:0] ctrl_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    serial_reg_port u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .frame_n(frame_n), .sdi(sdi),
        .sdo(sdo), .result_in(result_in), .status_in(status_in), .ctrl_o(ctrl_o)
    );

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends nbits (first 16 from word, extra ones after); returns the 16 bits read.
    task automatic frame(input logic [15:0] word, input int nbits, output logic [15:0] rd);
        rd = '0;
        frame_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 16) ? word[15-i] : 1'b1;
            wait_clk(4);
            if (i < 16) rd[15-i] = sdo;
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
        wait_clk(4);
        frame_n = 1'b1;
        sdi = 1'b0;
        wait_clk(4);
    endtask

    task automatic t_reset;
        logic [15:0] rd;
        check(ctrl_o == 14'h0, "R10 reset ctrl", 16'(ctrl_o), 16'h0);
        frame(16'h0000, 16, rd);
        check(rd == 16'h0ABC, "R5 R6 R7 default result read", rd, 16'h0ABC);
        result_in = 12'hFFF;
        frame(16'h0000, 16, rd);
        check(rd == 16'h0FFF, "R6 leading zeros", rd, 16'h0FFF);
        check(ctrl_o == 14'h0, "R10 sdi low keeps ctrl", 16'(ctrl_o), 16'h0);
    endtask

    task automatic t_test_reg;
        logic [15:0] rd;
        frame(16'h6A5B, 16, rd);
        frame(16'hC040, 16, rd);
        check(ctrl_o == 14'h0040, "R1 R3 ctrl write", 16'(ctrl_o), 16'h0040);
        frame(16'h0000, 16, rd);
        check(rd == 16'h2A5B, "R3 R4 test readback", rd, 16'h2A5B);
    endtask

    task automatic t_null_addr;
        logic [15:0] rd;
        frame(16'h3FFF, 16, rd);
        check(ctrl_o == 14'h0040, "R3 addr 00 ctrl unchanged", 16'(ctrl_o), 16'h0040);
        frame(16'h0000, 16, rd);
        check(rd == 16'h2A5B, "R3 addr 00 test unchanged", rd, 16'h2A5B);
    endtask

    task automatic t_partial;
        logic [15:0] rd;
        frame(16'hC0C0, 10, rd);
        check(ctrl_o == 14'h0040, "R2 partial frame dropped", 16'(ctrl_o), 16'h0040);
        frame(16'h0000, 16, rd);
        check(rd == 16'h2A5B, "R2 R5 selection kept after abort", rd, 16'h2A5B);
    endtask

    task automatic t_status;
        logic [15:0] rd;
        status_in = 16'hBEEF;
        frame(16'hC0C0, 16, rd);
        check(rd == 16'h2A5B, "R5 old selection in writing frame", rd, 16'h2A5B);
        frame(16'h0000, 16, rd);
        check(rd == 16'hBEEF, "R4 status read", rd, 16'hBEEF);
        status_in = 16'h1234;
        frame(16'h0000, 16, rd);
        check(rd == 16'h1234, "R5 sticky status", rd, 16'h1234);
    endtask

    task automatic t_long_frame;
        logic [15:0] rd;
        frame(16'hC000, 20, rd);
        check(ctrl_o == 14'h0, "R2 extra bits ignored", 16'(ctrl_o), 16'h0);
        frame(16'h0000, 16, rd);
        check(rd == 16'h0FFF, "R4 back to result", rd, 16'h0FFF);
    endtask

    task automatic t_cal_bank;
        logic [15:0] rd;
        frame(16'hC080, 16, rd);
        for (int i = 0; i < 10; i++) frame({2'b10, 14'(14'h1000 + i * 3)}, 16, rd);
        for (int i = 0; i < 11; i++) begin
            logic [15:0] exp;
            exp = {2'b00, 14'(14'h1000 + (i % 10) * 3)};
            frame(16'h0000, 16, rd);
            check(rd == exp, "R8 R9 full bank order and wrap", rd, exp);
        end
    endtask

    task automatic t_cal_subsets;
        logic [15:0] rd;
        logic [15:0] gain, offs;
        gain = 16'h1000;
        offs = 16'h1003;
        frame(16'hC081, 16, rd);
        frame(16'h0000, 16, rd); check(rd == gain, "R8 subset 01 first", rd, gain);
        frame(16'h0000, 16, rd); check(rd == offs, "R8 subset 01 second", rd, offs);
        frame(16'h0000, 16, rd); check(rd == gain, "R9 subset 01 wrap", rd, gain);
        frame(16'hC082, 16, rd);
        frame(16'h0000, 16, rd); check(rd == offs, "R8 subset 10", rd, offs);
        frame(16'h0000, 16, rd); check(rd == offs, "R9 subset 10 repeat", rd, offs);
        frame(16'hC083, 16, rd);
        frame(16'h0000, 16, rd); check(rd == gain, "R8 subset 11", rd, gain);
        frame(16'hC080, 16, rd);
        frame(16'h0000, 16, rd); check(rd == gain, "R9 pointer reset on ctrl write", rd, gain);
        frame(16'h0000, 16, rd); check(rd == offs, "R9 step after reset", rd, offs);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_test_reg();
        t_null_addr();
        t_partial();
        t_status();
        t_long_frame();
        t_cal_bank();
        t_cal_subsets();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule